// File: doc/BRIEF.md
# Guarded Watchdog Timer with Selectable Prescaler

This block watches for a stalled program. A down-counter is clocked by ticks from a prescaler that divides the system clock. Software must write the refresh strobe often enough to keep the counter from running out. When the counter runs past zero, the block raises one of two outputs for a single clock cycle: an interrupt request or a system reset request. A mode bit picks which one, and once software sets that bit to "reset" it cannot clear it.

The timer does nothing after reset until the first refresh write. The prescaler ratio comes from a divide-select bit. A flag reporting that the slow sub clock drives the CPU overrides that bit. The mode bits, which are the underflow action and the protected count source, change only while a separate write-enable bit is set. A low-power hold input freezes the count. In protected-source mode the prescaler advances only on pulses from an independent oscillator, and the hold input no longer freezes it.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `running_o` is 0, `cnt_o` holds the full value (all ones), `act_o`, `src_o` and `prot_o` are 0, and no pulse appears on `irq_o` or `wdt_rst_o` until the first `kick_we` write.
- R2: A `kick_we` write reloads the counter to full and clears the prescaler. The underflow pulse then appears in the cycle after rising edge number 2^CNT_W × ratio + 1, counting the edge that samples `kick_we` as edge 0. A later refresh write restarts this count from its own edge.
- R3: With `sub_clk_sel` = 0, a `div_sel_d` value of 0 written with `div_we` gives a ratio of DIV_LO (16), and a value of 1 gives DIV_HI (128). The counter first decrements on edge ratio + 1 after the refresh edge.
- R4: With `sub_clk_sel` = 1, the ratio is DIV_SUB (2) whatever the divide-select bit holds.
- R5: The action bit `act_o` is set to 1 by a permitted mode write with `mode_act_d` = 1. A later mode write with `mode_act_d` = 0 leaves it at 1. Only reset clears it.
- R6: A `mode_we` write changes `act_o` and `src_o` only while `prot_o` is 1. `prot_o` follows `prot_d` on every `prot_we`.
- R7: On underflow the counter reloads to full and keeps counting. With `act_o` = 0 the block pulses `irq_o` high for one cycle. With `act_o` = 1 it pulses `wdt_rst_o` instead. The two pulses never occur together, and the next underflow follows one full period later.
- R8: While `lp_hold` is 1 and `src_o` is 0, the counter and the prescaler hold their values. Counting resumes from there, so the underflow moves later by exactly the number of held cycles.
- R9: While `src_o` is 1, the prescaler advances only on cycles where `ring_tick` is 1, and `lp_hold` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_we | input | 1 | Refresh strobe: starts or reloads the timer |
| div_we | input | 1 | Write strobe for the divide-select bit |
| div_sel_d | input | 1 | Divide select: 0 gives DIV_LO, 1 gives DIV_HI |
| mode_we | input | 1 | Write strobe for the guarded mode bits |
| mode_act_d | input | 1 | Action data: 1 sets reset-on-underflow |
| mode_src_d | input | 1 | Count source data: 1 selects the protected source |
| prot_we | input | 1 | Write strobe for the mode write-enable bit |
| prot_d | input | 1 | Mode write-enable data |
| sub_clk_sel | input | 1 | CPU runs from the sub clock; forces ratio DIV_SUB |
| lp_hold | input | 1 | Stop, wait or hold state is active |
| ring_tick | input | 1 | Enable pulse from the independent oscillator |
| irq_o | output | 1 | One-cycle interrupt request on underflow |
| wdt_rst_o | output | 1 | One-cycle reset request on underflow |
| cnt_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Timer started since reset |
| act_o | output | 1 | Underflow action bit |
| src_o | output | 1 | Protected count source bit |
| prot_o | output | 1 | Mode write-enable bit |

## Verification
The bench predicts the exact cycle of every underflow pulse and checks each observed pulse against that prediction, both its timing and its kind. An off-by-one in the prescaler wrap, or a refresh that fails to clear the prescaler, moves a pulse by a cycle or more and is reported. The bench tries to clear the action bit and writes the mode bits while they are guarded. A sticky bit that clears, or a guard that leaks, shows up on the readback and as the wrong pulse kind. It also checks the hold freeze, which must delay the pulse by exactly the held cycles, the sub-clock override of the divide bit, and a protected source that must ignore hold yet stall without `ring_tick`.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    ACT_IRQ = 1'b0,
    ACT_RST = 1'b1
  } wdt_act_e;

  typedef struct packed {
    logic     prot;
    wdt_act_e act;
    logic     src;
  } wdt_mode_t;

endpackage

// File: rtl/wdt_mode_regs.sv
module wdt_mode_regs
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      div_we,
  input  logic      div_sel_d,
  input  logic      mode_we,
  input  logic      mode_act_d,
  input  logic      mode_src_d,
  input  logic      prot_we,
  input  logic      prot_d,
  output wdt_mode_t mode_o,
  output logic      div_sel_o
);

  wdt_mode_t mode_q;
  logic      div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{prot: 1'b0, act: ACT_IRQ, src: 1'b0};
      div_q  <= 1'b0;
    end else begin
      if (prot_we) mode_q.prot <= prot_d;
      if (mode_we && mode_q.prot) begin
        if (mode_act_d) mode_q.act <= ACT_RST;
        mode_q.src <= mode_src_d;
      end
      if (div_we) div_q <= div_sel_d;
    end
  end

  assign mode_o    = mode_q;
  assign div_sel_o = div_q;

  // R5: once reset-on-underflow is chosen it stays chosen
  p_act_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q.act == ACT_RST) |=> (mode_q.act == ACT_RST));

  // R6: guarded bits ignore writes while the enable is low
  p_prot_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !mode_q.prot) |=> ($stable(mode_q.act) && $stable(mode_q.src)));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2,
  parameter int PW      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  input  logic freeze_i,
  input  logic src_i,
  input  logic ring_tick_i,
  input  logic sub_i,
  input  logic div_sel_i,
  output logic tick_o
);

  localparam logic [PW-1:0] R_LO  = PW'(DIV_LO);
  localparam logic [PW-1:0] R_HI  = PW'(DIV_HI);
  localparam logic [PW-1:0] R_SUB = PW'(DIV_SUB);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] ratio_w;
  logic          adv_w;
  logic          wrap_w;
  logic          tick_q;

  always_comb begin
    if (sub_i)          ratio_w = R_SUB;
    else if (div_sel_i) ratio_w = R_HI;
    else                ratio_w = R_LO;
  end

  assign adv_w  = run_i && (src_i ? ring_tick_i : !freeze_i);
  assign wrap_w = (pre_q >= ratio_w - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= adv_w && wrap_w;
      if (adv_w) pre_q <= wrap_w ? '0 : pre_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R8: a hold on the normal source freezes the divider
  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (!src_i && freeze_i && !clr_i) |=> $stable(pre_q));

  // R9: protected source advances only on oscillator pulses
  p_ring_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (src_i && !ring_tick_i && !clr_i) |=> $stable(pre_q));

  // R2: a refresh empties the divider
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pre_q == '0 && !tick_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick_i,
  input  logic             tick_i,
  input  wdt_act_e         act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             irq_o,
  output logic             wrst_o
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             irq_q;
  logic             wrst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= FULL;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      wrst_q <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      wrst_q <= 1'b0;
      if (kick_i) begin
        cnt_q <= FULL;
        run_q <= 1'b1;
      end else if (tick_i) begin
        if (cnt_q == '0) begin
          cnt_q <= FULL;
          if (act_i == ACT_RST) wrst_q <= 1'b1;
          else                  irq_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign irq_o  = irq_q;
  assign wrst_o = wrst_q;

  // R1: idle timer sits at full and stays quiet
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (cnt_q == FULL && !irq_q && !wrst_q));

  // R2: refresh reloads the full value
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (cnt_q == FULL));

  // R8: without a tick or refresh the count holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!kick_i && !tick_i) |=> $stable(cnt_q));

  // R7: pulses are single-cycle and never both at once
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_q || wrst_q) |=> !(irq_q || wrst_q));

  p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(irq_q && wrst_q));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int DIV_LO  = 16,
  parameter int DIV_HI  = 128,
  parameter int DIV_SUB = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick_we,
  input  logic             div_we,
  input  logic             div_sel_d,
  input  logic             mode_we,
  input  logic             mode_act_d,
  input  logic             mode_src_d,
  input  logic             prot_we,
  input  logic             prot_d,
  input  logic             sub_clk_sel,
  input  logic             lp_hold,
  input  logic             ring_tick,
  output logic             irq_o,
  output logic             wdt_rst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             act_o,
  output logic             src_o,
  output logic             prot_o
);

  localparam int DIV_A   = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int DIV_TOP = (DIV_A > DIV_SUB) ? DIV_A : DIV_SUB;
  localparam int PW      = $clog2(DIV_TOP + 1);

  wdt_mode_t mode_w;
  logic      div_sel_w;
  logic      tick_w;
  logic      run_w;

  wdt_mode_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .div_we     (div_we),
    .div_sel_d  (div_sel_d),
    .mode_we    (mode_we),
    .mode_act_d (mode_act_d),
    .mode_src_d (mode_src_d),
    .prot_we    (prot_we),
    .prot_d     (prot_d),
    .mode_o     (mode_w),
    .div_sel_o  (div_sel_w)
  );

  wdt_prescaler #(
    .DIV_LO  (DIV_LO),
    .DIV_HI  (DIV_HI),
    .DIV_SUB (DIV_SUB),
    .PW      (PW)
  ) u_pre (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (kick_we),
    .run_i       (run_w),
    .freeze_i    (lp_hold),
    .src_i       (mode_w.src),
    .ring_tick_i (ring_tick),
    .sub_i       (sub_clk_sel),
    .div_sel_i   (div_sel_w),
    .tick_o      (tick_w)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .kick_i (kick_we),
    .tick_i (tick_w),
    .act_i  (mode_w.act),
    .cnt_o  (cnt_o),
    .run_o  (run_w),
    .irq_o  (irq_o),
    .wrst_o (wdt_rst_o)
  );

  assign running_o = run_w;
  assign act_o     = (mode_w.act == ACT_RST);
  assign src_o     = mode_w.src;
  assign prot_o    = mode_w.prot;

  // R1: the divider produces no tick before the first refresh
  p_no_tick_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !run_w |-> !tick_w);

endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 5;
  localparam int FULL       = (1 << CW) - 1;
  localparam int SPAN       = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kick_we = 0, div_we = 0, div_sel_d = 0, mode_we = 0, mode_act_d = 0;
  logic mode_src_d = 0, prot_we = 0, prot_d = 0, sub_clk_sel = 0, lp_hold = 0;
  logic ring_tick = 0;
  logic irq_o, wdt_rst_o, running_o, act_o, src_o, prot_o;
  logic [CW-1:0] cnt_o;

  wdt_guard #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .kick_we(kick_we), .div_we(div_we),
    .div_sel_d(div_sel_d), .mode_we(mode_we), .mode_act_d(mode_act_d),
    .mode_src_d(mode_src_d), .prot_we(prot_we), .prot_d(prot_d),
    .sub_clk_sel(sub_clk_sel), .lp_hold(lp_hold), .ring_tick(ring_tick),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o), .cnt_o(cnt_o),
    .running_o(running_o), .act_o(act_o), .src_o(src_o), .prot_o(prot_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    is_rst;
    string tag;
  } exp_t;
  exp_t scb[$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares each observed pulse with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && (irq_o || wdt_rst_o)) begin
      if (scb.size() == 0) begin
        check(1'b0, "R1/R7", "unexpected pulse at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = scb.pop_front();
        check(cyc == e.at, e.tag, "pulse cycle", cyc, e.at);
        check(wdt_rst_o == e.is_rst, e.tag, "pulse kind (1=reset)",
              int'(wdt_rst_o), int'(e.is_rst));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1; kick_we = 0; div_we = 0; mode_we = 0; prot_we = 0;
    sub_clk_sel = 0; lp_hold = 0; ring_tick = 0;
    scb.delete();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr_prot(input bit v);
    prot_d = v; prot_we = 1;
    @(negedge clk); prot_we = 0;
  endtask

  task automatic wr_mode(input bit a, input bit s);
    mode_act_d = a; mode_src_d = s; mode_we = 1;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_div(input bit v);
    div_sel_d = v; div_we = 1;
    @(negedge clk); div_we = 0;
  endtask

  // driver: refresh, then queue the predicted pulses
  task automatic kick(input int ratio, input int npulse, input bit kind,
                      input int extra, input string tag, output int k);
    kick_we = 1;
    @(posedge clk); #1;
    k = cyc;
    @(negedge clk); kick_we = 0;
    for (int i = 1; i <= npulse; i++)
      scb.push_back('{at: k + i * SPAN * ratio + 1 + extra, is_rst: kind, tag: tag});
  endtask

  task automatic drain(input int cycles, input string tag);
    repeat (cycles) @(negedge clk);
    check(scb.size() == 0, tag, "pulses still pending", scb.size(), 0);
    scb.delete();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    int k;
    int held;

    // R1: reset state and idle
    do_reset();
    check(int'(cnt_o) == FULL, "R1", "cnt after reset", int'(cnt_o), FULL);
    check(running_o == 0, "R1", "running after reset", int'(running_o), 0);
    check({act_o, src_o, prot_o} == 3'b000, "R1", "mode bits after reset",
          int'({act_o, src_o, prot_o}), 0);
    repeat (2000) @(negedge clk);
    check(int'(cnt_o) == FULL, "R1", "cnt while idle", int'(cnt_o), FULL);
    check(running_o == 0, "R1", "running while idle", int'(running_o), 0);

    // R3 / R7: divide 16, two interrupt periods back to back
    kick(16, 2, 1'b0, 0, "R7", k);
    repeat (16) @(negedge clk);
    check(int'(cnt_o) == FULL, "R3", "cnt before first tick", int'(cnt_o), FULL);
    @(negedge clk);
    check(int'(cnt_o) == FULL - 1, "R3", "cnt after first tick", int'(cnt_o), FULL - 1);
    drain(2 * SPAN * 16 + 40, "R7");

    // R3: divide 128
    do_reset();
    wr_div(1'b1);
    kick(128, 1, 1'b0, 0, "R3", k);
    drain(SPAN * 128 + 40, "R3");

    // R4: sub clock forces divide 2 even with divide-select at 1
    do_reset();
    wr_div(1'b1);
    sub_clk_sel = 1;
    kick(2, 2, 1'b0, 0, "R4", k);
    drain(2 * SPAN * 2 + 20, "R4");

    // R2: a second refresh restarts the period
    do_reset();
    kick(16, 0, 1'b0, 0, "R2", k);
    repeat (300) @(negedge clk);
    check(int'(cnt_o) < FULL, "R2", "counting before refresh", int'(cnt_o), FULL - 1);
    kick(16, 1, 1'b0, 0, "R2", k);
    check(int'(cnt_o) == FULL, "R2", "cnt after refresh", int'(cnt_o), FULL);
    drain(SPAN * 16 + 40, "R2");

    // R6 / R5: guarded writes and the sticky action bit
    do_reset();
    wr_mode(1'b1, 1'b1);
    check(act_o == 0, "R6", "act after guarded write", int'(act_o), 0);
    check(src_o == 0, "R6", "src after guarded write", int'(src_o), 0);
    wr_prot(1'b1);
    check(prot_o == 1, "R6", "write enable set", int'(prot_o), 1);
    wr_mode(1'b1, 1'b0);
    check(act_o == 1, "R5", "act set", int'(act_o), 1);
    wr_mode(1'b0, 1'b0);
    check(act_o == 1, "R5", "act after clear attempt", int'(act_o), 1);
    wr_prot(1'b0);
    check(prot_o == 0, "R6", "write enable cleared", int'(prot_o), 0);
    kick(16, 1, 1'b1, 0, "R7", k);
    drain(SPAN * 16 + 40, "R7");

    // R8: low-power hold freezes and shifts the underflow
    do_reset();
    kick(16, 0, 1'b0, 0, "R8", k);
    repeat (100) @(negedge clk);
    held = int'(cnt_o);
    lp_hold = 1;
    repeat (50) @(negedge clk);
    check(int'(cnt_o) == held, "R8", "cnt during hold", int'(cnt_o), held);
    lp_hold = 0;
    scb.push_back('{at: k + SPAN * 16 + 1 + 50, is_rst: 1'b0, tag: "R8"});
    drain(SPAN * 16 + 40, "R8");

    // R9: protected source ignores hold and needs the oscillator pulse
    do_reset();
    wr_prot(1'b1);
    wr_mode(1'b0, 1'b1);
    wr_prot(1'b0);
    check(src_o == 1, "R9", "protected source selected", int'(src_o), 1);
    kick(16, 0, 1'b0, 0, "R9", k);
    repeat (200) @(negedge clk);
    check(int'(cnt_o) == FULL, "R9", "cnt with no oscillator pulse", int'(cnt_o), FULL);
    ring_tick = 1;
    lp_hold = 1;
    kick(16, 1, 1'b0, 0, "R9", k);
    drain(SPAN * 16 + 40, "R9");
    lp_hold = 0;

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      summary();
      $finish;
    end
  end

endmodule